// File: doc/BRIEF.md
# Lockable Bus Error Status Register

This block keeps the error state of one node on a shared system bus. The bus interface logic sends single-cycle event pulses, one line per error type. Each pulse sets a matching sticky bit in a 32-bit status register. Some error types freeze the whole register as soon as they are recorded. The first failure therefore stays intact for diagnosis, and later events cannot overwrite it. Syndrome-only events normally leave the register open. A lock-on-first-error enable in a companion configuration register makes every recorded event a freezing one.

Software reaches both registers through a small register port. A select line picks the register, a write strobe writes it, and read data is combinational. Status bits are cleared by writing ones to them. The register unfreezes in either of two cases: software clears every bit, or software turns the lock-on-first-error enable off. The configuration register also holds disable bits. Two of them suppress the two timeout events entirely. Two of them hide the correctable data errors from the interrupt output. The interrupt output is a level signal.

Top module: `bus_err_capture`

## Requirements
- R1: After a synchronous active-low reset, both registers read zero, `locked_o` is low and `err_irq_o` is low.
- R2: An event pulse on `evt_i[i]` sets status bit i, and the bit stays set until software clears it. Bits 11 to 15 are unimplemented: events on them are ignored and the bits always read 0.
- R3: While unlocked, recording an event on any bit outside the syndrome field (bits 20 to 23) sets `locked_o` in the next cycle.
- R4: While configuration bit 31 (lock-on-first-error) is 0, syndrome-only events (bits 20 to 23) do not lock. While it is 1, they do lock.
- R5: While locked, incoming events change no status bit.
- R6: A status write (`reg_sel_i`=0) clears every status bit whose `reg_wdata_i` bit is 1. It leaves every bit whose `reg_wdata_i` bit is 0 unchanged.
- R7: A locked register unlocks when the status value after a write-clear is zero. Events arriving in that same cycle are ignored.
- R8: A locked register unlocks when a configuration write changes bit 31 from 1 to 0. The status bits are kept.
- R9: Configuration bit 2 set blocks event bit 3 (bank lock timeout). Configuration bit 3 set blocks event bit 31 (data timeout). A blocked event neither sets its bit nor locks.
- R10: `err_irq_o` is high when any status bit is set, with these exceptions: bit 17 does not count when configuration bit 0 is set, and bits 18 and 19 do not count when configuration bit 1 is set. Masked bits still record.
- R11: `reg_sel_i`=1 addresses the configuration register. Only its bits 0 to 3 and 31 are stored, and the other bits read 0. `reg_rdata_o` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Error event pulses, one per status bit |
| reg_sel_i | input | 1 | Register select: 0 status, 1 configuration |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data (ones to clear for status) |
| reg_rdata_o | output | 32 | Read data of the selected register |
| locked_o | output | 1 | Status register is frozen |
| err_irq_o | output | 1 | Error interrupt level |

## Verification
Several properties are checked on every cycle:
- recorded bits never fall without a status write;
- a frozen register holds still;
- a non-syndrome event locks;
- a disabled bank-lock timeout cannot appear;
- the interrupt stays low when the status is empty;
- a falling lock-on-first-error enable releases the lock.

Other behaviour needs the bench's directed sequences, checked against its cycle-by-cycle model. These cover clear-and-event collisions in the unlock cycle, syndrome-only locking under the enable, the exact interrupt masking of the correctable bits, and the configuration read-back mask.

// File: rtl/berr_pkg.sv
// Package: shared bit positions and masks for the bus error capture block.
// Assumes a 32-bit status and configuration register.
package berr_pkg;
    localparam int REG_W = 32;
    // implemented status bits (11..15 unused)
    localparam logic [REG_W-1:0] IMPL_MASK = 32'hFFFF_07FF;
    // data syndrome field that does not lock on its own
    localparam logic [REG_W-1:0] SYND_MASK = 32'h00F0_0000;
    localparam int BIT_LOCK_TMO = 3;
    localparam int BIT_DATA_TMO = 31;
    localparam int BIT_CWR      = 17;
    localparam int BIT_CRD_LO   = 18;
    localparam int BIT_CRD_HI   = 19;
    localparam int CFG_CWR_DIS  = 0;
    localparam int CFG_CRD_DIS  = 1;
    localparam int CFG_LKTO_DIS = 2;
    localparam int CFG_DTO_DIS  = 3;
    localparam int CFG_LOFE     = 31;
    localparam logic [REG_W-1:0] CFG_MASK = 32'h8000_000F;
    typedef enum logic {SEL_STATUS = 1'b0, SEL_CONFIG = 1'b1} reg_sel_e;
endpackage

// File: rtl/berr_event_gate.sv
// Event gate: drops events on unimplemented bits and events whose
// timeout type is disabled by configuration. Purely combinational.
module berr_event_gate
    import berr_pkg::*;
(
    input  logic [REG_W-1:0] evt_i,
    input  logic             lkto_dis_i,
    input  logic             dto_dis_i,
    output logic [REG_W-1:0] gated_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == BIT_LOCK_TMO) begin : g_lkto
            // bank lock timeout may be disabled
            assign gated_o[i] = evt_i[i] & ~lkto_dis_i;
        end else if (i == BIT_DATA_TMO) begin : g_dto
            // data timeout may be disabled
            assign gated_o[i] = evt_i[i] & ~dto_dis_i;
        end else if (IMPL_MASK[i]) begin : g_pass
            // ordinary implemented bit
            assign gated_o[i] = evt_i[i];
        end else begin : g_none
            // unimplemented bit never records
            assign gated_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/berr_status_reg.sv
// Sticky status bits: write-one-to-clear, set by gated events only
// while unlocked. Exposes the next value for the unlock decision.
module berr_status_reg
    import berr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             clr_en_i,
    input  logic [REG_W-1:0] clr_mask_i,
    input  logic [REG_W-1:0] set_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] status_nxt_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic q;
            // next value: clear first, then set when open
            assign status_nxt_o[i] = (q & ~(clr_en_i & clr_mask_i[i])) | (~lock_i & set_i[i]);
            // register one sticky bit
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= status_nxt_o[i];
            end
            assign status_o[i] = q;
        end else begin : g_tie
            // unimplemented bit reads zero
            assign status_nxt_o[i] = 1'b0;
            assign status_o[i]     = 1'b0;
        end
    end
endmodule

// File: rtl/berr_lock_ctrl.sv
// Lock control: closes on a non-syndrome event, or on any event while
// lock-on-first-error is set; opens when the post-write status is empty
// or when lock-on-first-error is turned off.
module berr_lock_ctrl
    import berr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             lofe_i,
    input  logic             lofe_fall_i,
    input  logic [REG_W-1:0] status_nxt_i,
    output logic             locked_o
);
    logic close_req, open_req;

    // decide closing and opening conditions
    always_comb begin
        close_req = (|(set_i & ~SYND_MASK)) || (lofe_i && (|set_i));
        open_req  = (status_nxt_i == '0) || lofe_fall_i;
    end

    // lock state register
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_o <= 1'b0;
        else if (locked_o) locked_o <= !open_req;
        else               locked_o <= close_req;
    end
endmodule

// File: rtl/bus_err_capture.sv
// Top: bus error status register with lock-on-first-error, config
// register, register port and interrupt. Assumes one-cycle event pulses
// and single-cycle register writes.
module bus_err_capture
    import berr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             locked_o,
    output logic             err_irq_o
);
    logic [REG_W-1:0] cfg_q, evt_gated, status_q, status_nxt, irq_mask;
    logic             st_wr, cfg_wr, lofe_fall;
    reg_sel_e         sel;

    // decode register port strobes
    always_comb begin
        sel       = reg_sel_e'(reg_sel_i);
        st_wr     = reg_wr_i && (sel == SEL_STATUS);
        cfg_wr    = reg_wr_i && (sel == SEL_CONFIG);
        lofe_fall = cfg_wr && cfg_q[CFG_LOFE] && !reg_wdata_i[CFG_LOFE];
    end

    // configuration register, implemented bits only
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= reg_wdata_i & CFG_MASK;
    end

    berr_event_gate u_gate (
        .evt_i      (evt_i),
        .lkto_dis_i (cfg_q[CFG_LKTO_DIS]),
        .dto_dis_i  (cfg_q[CFG_DTO_DIS]),
        .gated_o    (evt_gated)
    );

    berr_status_reg u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_i       (locked_o),
        .clr_en_i     (st_wr),
        .clr_mask_i   (reg_wdata_i),
        .set_i        (evt_gated),
        .status_o     (status_q),
        .status_nxt_o (status_nxt)
    );

    berr_lock_ctrl u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (evt_gated),
        .lofe_i       (cfg_q[CFG_LOFE]),
        .lofe_fall_i  (lofe_fall),
        .status_nxt_i (status_nxt),
        .locked_o     (locked_o)
    );

    // interrupt mask from correctable-error disables, and read mux
    always_comb begin
        irq_mask             = '1;
        irq_mask[BIT_CWR]    = ~cfg_q[CFG_CWR_DIS];
        irq_mask[BIT_CRD_LO] = ~cfg_q[CFG_CRD_DIS];
        irq_mask[BIT_CRD_HI] = ~cfg_q[CFG_CRD_DIS];
        err_irq_o            = |(status_q & irq_mask);
        reg_rdata_o          = (sel == SEL_CONFIG) ? cfg_q : status_q;
    end

    // R2
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !st_wr) |=> (status_q == $past(status_q)));

    // R3
    nonsynd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && (|(evt_gated & ~SYND_MASK))) |=> locked_o);

    // R8
    lofe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && lofe_fall) |=> !locked_o);

    // R9
    lkto_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CFG_LKTO_DIS] && !status_q[BIT_LOCK_TMO]) |=> !status_q[BIT_LOCK_TMO]);

    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !err_irq_o);
endmodule

// File: tb/sim_bus_err_capture.sv
`timescale 1ns/1ps
module sim_bus_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        reg_sel_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        locked_o, err_irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] m_st = '0;
    logic [31:0] m_cfg = '0;
    bit          m_lk = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_err_capture u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_sel_i(reg_sel_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .locked_o(locked_o), .err_irq_o(err_irq_o)
    );

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_irq();
        bit any = 0;
        for (int i = 0; i < 32; i++) begin
            bit hidden = 0;
            if (i == 17 && m_cfg[0]) hidden = 1;
            if ((i == 18 || i == 19) && m_cfg[1]) hidden = 1;
            if (m_st[i] && !hidden) any = 1;
        end
        return any;
    endfunction

    task automatic compare_all(input string tag);
        cmp(tag, "rdata", reg_rdata_o, reg_sel_i ? m_cfg : m_st);
        cmp(tag, "locked", {31'b0, locked_o}, {31'b0, m_lk});
        cmp(tag, "irq", {31'b0, err_irq_o}, {31'b0, model_irq()});
    endtask

    // apply one cycle of stimulus, advance model, compare at negedge
    task automatic step(input string tag, input logic [31:0] ev, input bit wr, input bit sel, input logic [31:0] wd);
        logic [31:0] g, nst;
        bit nlk, open_c;
        evt_i = ev; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
        @(posedge clk);
        g = ev;
        for (int i = 11; i <= 15; i++) g[i] = 1'b0;
        if (m_cfg[2]) g[3] = 1'b0;
        if (m_cfg[3]) g[31] = 1'b0;
        nst = m_st;
        if (wr && !sel) nst = nst & ~wd;
        if (!m_lk) nst = nst | g;
        if (m_lk) begin
            open_c = (nst == 0) || (wr && sel && m_cfg[31] && !wd[31]);
            nlk = !open_c;
        end else begin
            nlk = ((g & 32'hFF0F_FFFF) != 0) || (g != 0 && m_cfg[31]);
        end
        if (wr && sel) m_cfg = wd & 32'h8000_000F;
        m_st = nst; m_lk = nlk;
        @(negedge clk);
        compare_all(tag);
        evt_i = '0; reg_wr_i = 1'b0;
    endtask

    task automatic rd(input string tag, input bit sel, input logic [31:0] exp);
        step(tag, '0, 1'b0, sel, '0);
        cmp(tag, "readback", reg_rdata_o, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        compare_all("R1");
        rd("R1", 1'b1, 32'h0);
        // R2 syndrome bits record, unused bit ignored; R4 no lock
        step("R2", 32'h0010_0000, 0, 0, 0);
        step("R2", 32'h0020_1000, 0, 0, 0);
        rd("R2", 1'b0, 32'h0030_0000);
        cmp("R4", "locked", {31'b0, locked_o}, 32'h0);
        // R6 write-one-to-clear; zero write keeps
        step("R6", 0, 1, 0, 32'h0010_0000);
        step("R6", 0, 1, 0, 32'h0);
        rd("R6", 1'b0, 32'h0020_0000);
        step("R7", 0, 1, 0, 32'hFFFF_FFFF);
        // R3 non-syndrome locks; R5 later event ignored; R10 irq high
        step("R3", 32'h0000_0010, 0, 0, 0);
        cmp("R3", "locked", {31'b0, locked_o}, 32'h1);
        step("R5", 32'h0000_0001, 0, 0, 0);
        rd("R5", 1'b0, 32'h0000_0010);
        cmp("R10", "irq", {31'b0, err_irq_o}, 32'h1);
        // R7 clear to zero with colliding event: unlock, event dropped
        step("R7", 32'h0000_0020, 1, 0, 32'h0000_0010);
        rd("R7", 1'b0, 32'h0);
        cmp("R7", "locked", {31'b0, locked_o}, 32'h0);
        // R4 with lock-on-first-error a syndrome event locks
        step("R4", 0, 1, 1, 32'h8000_0000);
        step("R4", 32'h0040_0000, 0, 0, 0);
        cmp("R4", "locked", {31'b0, locked_o}, 32'h1);
        step("R5", 32'h0000_0002, 0, 0, 0);
        // R8 turning the enable off releases, bits kept
        step("R8", 0, 1, 1, 32'h0);
        cmp("R8", "locked", {31'b0, locked_o}, 32'h0);
        rd("R8", 1'b0, 32'h0040_0000);
        step("R6", 0, 1, 0, 32'hFFFF_FFFF);
        // R9 disabled timeouts
        step("R9", 0, 1, 1, 32'h0000_000C);
        step("R9", 32'h8000_0008, 0, 0, 0);
        rd("R9", 1'b0, 32'h0);
        step("R9", 0, 1, 1, 32'h0);
        step("R9", 32'h8000_0000, 0, 0, 0);
        rd("R9", 1'b0, 32'h8000_0000);
        step("R9", 0, 1, 0, 32'hFFFF_FFFF);
        // R10 masked correctable errors record but stay quiet
        step("R10", 0, 1, 1, 32'h0000_0003);
        step("R10", 32'h0004_0000, 0, 0, 0);
        cmp("R10", "irq", {31'b0, err_irq_o}, 32'h0);
        step("R10", 0, 1, 0, 32'hFFFF_FFFF);
        step("R10", 32'h0002_0000, 0, 0, 0);
        cmp("R10", "irq", {31'b0, err_irq_o}, 32'h0);
        step("R10", 0, 1, 1, 32'h0);
        cmp("R10", "irq", {31'b0, err_irq_o}, 32'h1);
        step("R10", 0, 1, 0, 32'hFFFF_FFFF);
        // R11 configuration read-back mask
        step("R11", 0, 1, 1, 32'hFFFF_FFFF);
        rd("R11", 1'b1, 32'h8000_000F);
        step("R11", 0, 1, 1, 32'h0);
        // mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ev = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            int op = $urandom % 8;
            if (op == 0)      step("R6", ev, 1, 0, $urandom);
            else if (op == 1) step("R11", ev, 1, 1, $urandom);
            else              step("R2", ev, 0, op[0], 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule